// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Rates

This block is the alarm section of a calendar real-time clock. Software programs four byte-wide alarm registers (seconds, minutes, hours and day of month) through a small register port. Each register holds a BCD value in its low bits and a mask flag in bit 7. On every one-second strobe from the clock core, the block compares the programmed alarm against the current BCD time and, on a match, raises a one-cycle interrupt pulse.

The four mask flags together select how often the alarm repeats. With no flags set, all four fields must match, so the alarm fires once a month. Setting the day flag drops the day from the compare, so it fires daily. Adding the hour flag gives hourly, and adding the minute flag gives once a minute. Every other flag pattern makes the alarm fire on every strobe.

Writes whose BCD value falls outside the field's legal range are discarded. The register then keeps its previous contents. The time counter and any interrupt-enable gating sit outside this block.

Top module: `rtc_alarm`

## Requirements
- R1: While reset is asserted and afterwards until written, `alarm_irq` is 0 and the registers read seconds 0x00, minutes 0x00, hours 0x00, day 0x01.
- R2: Register select 0 is seconds and 1 is minutes. For these, the value is 10×bits[6:4] + bits[3:0]. A write is stored only if that value is at most 59; otherwise the old byte stays.
- R3: Register select 2 is hours. Its value is 10×bits[5:4] + bits[3:0], and a write is stored only if that value is at most 23.
- R4: Register select 3 is day of month. Its value is 10×bits[5:4] + bits[3:0], and a write is stored only if that value is nonzero.
- R5: `reg_rdata` always shows the full stored byte of the selected register, including the mask flag in bit 7 and any other upper bits that were written.
- R6: With all four mask flags clear, a strobe raises the interrupt only when the day (low 6 bits), hours (low 6), minutes (low 7) and seconds (low 7) all equal the current time.
- R7: With only the day flag set, the day is ignored; hours, minutes and seconds must match.
- R8: With the day and hour flags set and the others clear, only minutes and seconds must match.
- R9: With the day, hour and minute flags set and the seconds flag clear, only seconds must match.
- R10: Any other flag pattern, including all four set, raises the interrupt on every strobe.
- R11: A strobe sampled at a clock edge drives `alarm_irq` high for exactly the next cycle; no interrupt occurs in a cycle that did not follow a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 2 | Register select: 0 seconds, 1 minutes, 2 hours, 3 day |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored byte of the selected register |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-second strobe from the clock core |
| alarm_irq | output | 1 | One-cycle alarm pulse |

## Verification
The compare is driven in each repeat configuration with two kinds of time: one that matches every compared field, and one where exactly one field differs. This shows which fields each flag pattern actually drops from the compare. Flag patterns outside the four ladder steps are driven with fully mismatching times, which separates "fire every strobe" from a partial compare. A pseudo-random sweep of times in every configuration, run against a reference model, checks the whole decode. Write tests use values just inside and just outside each range, plus BCD codes with an illegal ones digit, to pin down the arithmetic range check.

// File: rtl/rtca_pkg.sv
package rtca_pkg;

   localparam int NUM_FIELDS = 4;

   typedef enum logic [2:0] {
      RPT_MONTH,
      RPT_DAY,
      RPT_HOUR,
      RPT_MIN,
      RPT_SEC
   } rpt_e;

   // field index: 0 seconds, 1 minutes, 2 hours, 3 day of month
   function automatic int field_bits(input int idx);
      return (idx < 2) ? 7 : 6;
   endfunction

   function automatic int field_min(input int idx);
      return (idx == 3) ? 1 : 0;
   endfunction

   function automatic int field_max(input int idx);
      case (idx)
         0, 1:    return 59;
         2:       return 23;
         default: return 63;
      endcase
   endfunction

   function automatic int field_rst(input int idx);
      return (idx == 3) ? 1 : 0;
   endfunction

endpackage

// File: rtl/rtca_field_reg.sv
module rtca_field_reg #(
   parameter int DATA_W   = 8,
   parameter int VAL_BITS = 7,
   parameter int MIN_VAL  = 0,
   parameter int MAX_VAL  = 59,
   parameter int RST_VAL  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] q
);
   localparam int             TENS_W = VAL_BITS - 4;
   localparam logic [7:0]     LO_LIM = 8'(MIN_VAL);
   localparam logic [7:0]     HI_LIM = 8'(MAX_VAL);
   localparam logic [DATA_W-1:0] RST_Q = DATA_W'(RST_VAL);

   initial begin : p_param_chk
      assert (VAL_BITS >= 5 && VAL_BITS < DATA_W && DATA_W == 8)
         else $error("rtca_field_reg: unsupported field width");
   end

   logic [TENS_W-1:0] tens;
   logic [3:0]        ones;
   logic [7:0]        dec_val;
   logic              in_range;

   assign tens    = wr_data[VAL_BITS-1:4];
   assign ones    = wr_data[3:0];
   assign dec_val = 8'(tens) * 8'd10 + 8'(ones);

   generate
      if (MIN_VAL == 0) begin : g_upper_only
         assign in_range = (dec_val <= HI_LIM);
      end else begin : g_both_limits
         assign in_range = (dec_val >= LO_LIM) && (dec_val <= HI_LIM);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                 q <= RST_Q;
      else if (wr_en && in_range) q <= wr_data;
   end

   // R2 (also R3, R4 per instance limits): rejected write leaves byte untouched
   a_r2_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_range) |=> $stable(q));

   // R2 (also R3, R4): accepted write stores the whole byte
   a_r2_accept_store: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range) |=> (q == $past(wr_data)));

endmodule

// File: rtl/rtca_mode_dec.sv
module rtca_mode_dec
   import rtca_pkg::*;
(
   input  logic [NUM_FIELDS-1:0] mask,
   output rpt_e                  mode
);
   // mask bit order follows field index: 0 sec, 1 min, 2 hour, 3 day
   always_comb begin
      case (mask)
         4'b0000: mode = RPT_MONTH;
         4'b1000: mode = RPT_DAY;
         4'b1100: mode = RPT_HOUR;
         4'b1110: mode = RPT_MIN;
         default: mode = RPT_SEC;
      endcase
   end
endmodule

// File: rtl/rtca_match.sv
module rtca_match
   import rtca_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  rpt_e                         mode,
   input  logic [NUM_FIELDS*DATA_W-1:0] alarm_v,
   input  logic [NUM_FIELDS*DATA_W-1:0] now_v,
   output logic                         irq
);
   logic [NUM_FIELDS-1:0] same;
   logic [NUM_FIELDS-1:0] need;
   logic                  hit;

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
         localparam int VB = field_bits(i);
         localparam logic [DATA_W-1:0] VMASK = DATA_W'((1 << VB) - 1);
         assign same[i] = ((alarm_v[i*DATA_W +: DATA_W] ^ now_v[i*DATA_W +: DATA_W])
                           & VMASK) == '0;
      end
   endgenerate

   always_comb begin
      case (mode)
         RPT_MONTH: need = 4'b1111;
         RPT_DAY:   need = 4'b0111;
         RPT_HOUR:  need = 4'b0011;
         RPT_MIN:   need = 4'b0001;
         default:   need = 4'b0000;
      endcase
   end

   assign hit = &(same | ~need);

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= tick & hit;
   end

   // R11: an interrupt cycle is always preceded by a strobe
   a_r11_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(tick));

   // R11: no strobe, no interrupt next cycle
   a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> !irq);

   // R10: per-second rate fires on every strobe
   a_r10_every_sec: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode == RPT_SEC) |=> irq);

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
   import rtca_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] now_sec,
   input  logic [DATA_W-1:0] now_min,
   input  logic [DATA_W-1:0] now_hour,
   input  logic [DATA_W-1:0] now_date,
   input  logic              sec_tick,
   output logic              alarm_irq
);
   localparam int VEC_W = NUM_FIELDS * DATA_W;

   logic [DATA_W-1:0]     regs [NUM_FIELDS];
   logic [VEC_W-1:0]      alarm_v;
   logic [VEC_W-1:0]      now_v;
   logic [NUM_FIELDS-1:0] mask;
   rpt_e                  mode;

   generate
      for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
         rtca_field_reg #(
            .DATA_W   (DATA_W),
            .VAL_BITS (field_bits(i)),
            .MIN_VAL  (field_min(i)),
            .MAX_VAL  (field_max(i)),
            .RST_VAL  (field_rst(i))
         ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr && (reg_sel == 2'(i))),
            .wr_data (reg_wdata),
            .q       (regs[i])
         );
         assign alarm_v[i*DATA_W +: DATA_W] = regs[i];
         assign mask[i] = regs[i][DATA_W-1];
      end
   endgenerate

   assign now_v     = {now_date, now_hour, now_min, now_sec};
   assign reg_rdata = regs[reg_sel];

   rtca_mode_dec u_dec (
      .mask (mask),
      .mode (mode)
   );

   rtca_match #(.DATA_W(DATA_W)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sec_tick),
      .mode    (mode),
      .alarm_v (alarm_v),
      .now_v   (now_v),
      .irq     (alarm_irq)
   );

   // R1: reset forces the interrupt low
   a_r1_reset_low: assert property (@(posedge clk)
      !rst_n |=> !alarm_irq);

endmodule

// File: tb/rtc_alarm_bench.sv
module rtc_alarm_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_date = 8'h01;
   logic       sec_tick = 1'b0;
   logic       alarm_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   rtc_alarm u_rtc_alarm (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
      .now_date(now_date), .sec_tick(sec_tick), .alarm_irq(alarm_irq)
   );

   // scoreboard queues, one entry per driven cycle
   bit         q_chk_rd [$];
   logic [7:0] q_rd     [$];
   logic       q_irq    [$];
   string      q_req    [$];

   // reference state
   logic [7:0] m_reg [4];

   function automatic bit m_accept(input int idx, input logic [7:0] v);
      int d;
      if (idx < 2) d = 10 * int'(v[6:4]) + int'(v[3:0]);
      else         d = 10 * int'(v[5:4]) + int'(v[3:0]);
      if (idx < 2)  return d <= 59;
      if (idx == 2) return d <= 23;
      return d != 0;
   endfunction

   function automatic bit m_fire(input logic [7:0] s, m, h, d);
      bit eq_s, eq_m, eq_h, eq_d;
      logic [3:0] f;
      eq_s = (s[6:0] == m_reg[0][6:0]);
      eq_m = (m[6:0] == m_reg[1][6:0]);
      eq_h = (h[5:0] == m_reg[2][5:0]);
      eq_d = (d[5:0] == m_reg[3][5:0]);
      f = {m_reg[3][7], m_reg[2][7], m_reg[1][7], m_reg[0][7]};
      case (f)
         4'b0000: return eq_s && eq_m && eq_h && eq_d;
         4'b1000: return eq_s && eq_m && eq_h;
         4'b1100: return eq_s && eq_m;
         4'b1110: return eq_s;
         default: return 1'b1;
      endcase
   endfunction

   // driver: one cycle of stimulus, pushes its expected outcome
   task automatic step(input bit tk, input logic [7:0] s, m, h, d,
                       input bit wr, input int sel, input logic [7:0] wd,
                       input bit chk_rd, input string req);
      @(negedge clk);
      sec_tick  = tk;
      now_sec   = s; now_min = m; now_hour = h; now_date = d;
      reg_wr    = wr;
      reg_sel   = 2'(sel);
      reg_wdata = wd;
      q_chk_rd.push_back(chk_rd && !wr);
      q_rd.push_back(m_reg[sel]);
      q_irq.push_back(rst_n && tk && m_fire(s, m, h, d));
      q_req.push_back(req);
      if (wr && rst_n && m_accept(sel, wd)) m_reg[sel] = wd;
   endtask

   task automatic wr_reg(input int sel, input logic [7:0] v, input string req);
      step(0, 8'h00, 8'h00, 8'h00, 8'h01, 1, sel, v, 0, req);
      step(0, 8'h00, 8'h00, 8'h00, 8'h01, 0, sel, 8'h00, 1, req);
   endtask

   task automatic tick_at(input logic [7:0] s, m, h, d, input string req);
      step(1, s, m, h, d, 0, 0, 8'h00, 0, req);
      step(0, s, m, h, d, 0, 0, 8'h00, 0, {req, "/R11"});
   endtask

   task automatic set_alarm(input logic [7:0] s, m, h, d);
      wr_reg(0, s, "R2"); wr_reg(1, m, "R2"); wr_reg(2, h, "R3"); wr_reg(3, d, "R4");
   endtask

   // monitor: compare after the edge that the previous driver step fed
   always @(posedge clk) begin
      #(CLK_P/4);
      if (q_irq.size() > 0) begin
         bit         c_rd;
         logic [7:0] e_rd;
         logic       e_irq;
         string      rq;
         c_rd  = q_chk_rd.pop_front();
         e_rd  = q_rd.pop_front();
         e_irq = q_irq.pop_front();
         rq    = q_req.pop_front();
         checks++;
         if (alarm_irq !== e_irq) begin
            fails++;
            $display("FAIL %s: alarm_irq=%0b expected %0b at %0t", rq, alarm_irq, e_irq, $time);
         end
         if (c_rd) begin
            checks++;
            if (reg_rdata !== e_rd) begin
               fails++;
               $display("FAIL %s: reg_rdata=%02h expected %02h at %0t", rq, reg_rdata, e_rd, $time);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] lf;
      m_reg[0] = 8'h00; m_reg[1] = 8'h00; m_reg[2] = 8'h00; m_reg[3] = 8'h01;
      // R1: reset state, a strobe during reset must not fire
      step(1, 8'h00, 8'h00, 8'h00, 8'h01, 0, 0, 8'h00, 0, "R1");
      step(0, 8'h00, 8'h00, 8'h00, 8'h01, 0, 0, 8'h00, 1, "R1");
      step(0, 8'h00, 8'h00, 8'h00, 8'h01, 0, 1, 8'h00, 1, "R1");
      step(0, 8'h00, 8'h00, 8'h00, 8'h01, 0, 2, 8'h00, 1, "R1");
      step(0, 8'h00, 8'h00, 8'h00, 8'h01, 0, 3, 8'h00, 1, "R1");
      @(negedge clk); rst_n = 1'b1;
      q_chk_rd.push_back(0); q_rd.push_back(8'h00); q_irq.push_back(0); q_req.push_back("R1");

      // R2: seconds and minutes range
      wr_reg(0, 8'h45, "R2");
      wr_reg(0, 8'h5A, "R2");   // 60 rejected
      wr_reg(0, 8'h60, "R2");   // rejected
      wr_reg(0, 8'h4F, "R2");   // 55 accepted
      wr_reg(1, 8'h59, "R2");
      wr_reg(1, 8'h7F, "R2");   // 85 rejected
      // R3: hours range, R5 mask bit read back
      wr_reg(2, 8'h23, "R3");
      wr_reg(2, 8'h24, "R3");
      wr_reg(2, 8'h3F, "R3");
      wr_reg(2, 8'h92, "R3/R5");
      // R4: day must be nonzero
      wr_reg(3, 8'h00, "R4");
      wr_reg(3, 8'hC0, "R4");
      wr_reg(3, 8'h15, "R4");
      wr_reg(3, 8'hC9, "R4/R5");

      // R6: monthly
      set_alarm(8'h30, 8'h15, 8'h08, 8'h12);
      tick_at(8'h30, 8'h15, 8'h08, 8'h12, "R6");
      tick_at(8'h30, 8'h15, 8'h08, 8'h13, "R6");
      tick_at(8'h31, 8'h15, 8'h08, 8'h12, "R6");
      step(0, 8'h30, 8'h15, 8'h08, 8'h12, 0, 0, 8'h00, 0, "R11");
      // R7: daily
      wr_reg(3, 8'h92, "R7");
      tick_at(8'h30, 8'h15, 8'h08, 8'h05, "R7");
      tick_at(8'h30, 8'h15, 8'h09, 8'h05, "R7");
      // R8: hourly
      wr_reg(2, 8'h88, "R8");
      tick_at(8'h30, 8'h15, 8'h17, 8'h22, "R8");
      tick_at(8'h30, 8'h16, 8'h17, 8'h22, "R8");
      // R9: every minute
      wr_reg(1, 8'h95, "R9");
      tick_at(8'h30, 8'h44, 8'h03, 8'h01, "R9");
      tick_at(8'h29, 8'h15, 8'h08, 8'h12, "R9");
      // R10: every second, several flag patterns
      wr_reg(0, 8'hB0, "R10");
      tick_at(8'h01, 8'h02, 8'h03, 8'h04, "R10");
      set_alarm(8'h80, 8'h15, 8'h08, 8'h12);
      tick_at(8'h01, 8'h02, 8'h03, 8'h04, "R10");
      set_alarm(8'h30, 8'h95, 8'h08, 8'h92);
      tick_at(8'h01, 8'h02, 8'h03, 8'h04, "R10");

      // sweep: each flag pattern against pseudo-random times
      lf = 8'h5B;
      for (int cfg = 0; cfg < 6; cfg++) begin
         case (cfg)
            0: set_alarm(8'h07, 8'h03, 8'h02, 8'h01);
            1: set_alarm(8'h07, 8'h03, 8'h02, 8'h81);
            2: set_alarm(8'h07, 8'h03, 8'h82, 8'h81);
            3: set_alarm(8'h07, 8'h83, 8'h82, 8'h81);
            4: set_alarm(8'h87, 8'h03, 8'h82, 8'h01);
            default: set_alarm(8'h87, 8'h83, 8'h82, 8'h81);
         endcase
         for (int k = 0; k < 24; k++) begin
            logic [7:0] s, m, h, d;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            s = {5'h0, lf[2:0]}; m = {6'h0, lf[4:3]};
            h = {6'h0, lf[6:5]}; d = {7'h0, lf[7]} | 8'h01;
            case (cfg)
               0: tick_at(s, m, h, d, "R6");
               1: tick_at(s, m, h, d, "R7");
               2: tick_at(s, m, h, d, "R8");
               3: tick_at(s, m, h, d, "R9");
               default: tick_at(s, m, h, d, "R10");
            endcase
         end
      end

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule